// File: doc/BRIEF.md
# Display Controller Command Sequencer

This block takes the command bytes that a host sends to a dot-matrix panel controller and turns them into the controller's configuration state. Each byte arrives with a one-cycle valid strobe. The block decodes the byte and updates the display switches, the contrast level, the indicator and step-up settings, the power control bits and the addressing registers. These values appear on output ports on the clock edge after the byte arrives. The panel drive, the analog supplies and the display RAM sit downstream and read these outputs.

Three commands take a second byte. These are the contrast set, indicator on and step-up ratio select. After one of them, the decoder treats the next byte as the data value, whatever that byte contains, and then returns to decoding commands.

The display and all-points commands can also put the controller into power save. The block then reports whether the state is sleep or standby. It drives the oscillator and supply enables and a blanking output that is active low.

Top module: `lcd_cmd_seq`

## Requirements
- R1: After the hardware reset:
  - `disp_on`, `reverse`, `all_on`, `ind_on` and `com_flip` are 0.
  - `pwr_ctrl`, `ind_mode`, `boost_sel`, `res_ratio`, `start_line`, `page_addr` and `col_addr` are 0.
  - `contrast` is 6'b100000.
  - `power_save` is 0, `await_data` is 0, and `blank_n` is 1, including while reset is held.
- R2: The single-byte display commands take effect on the clock edge that accepts them:
  - 0x01 sets `disp_on` to 0 and 0x02 sets it to 1.
  - 0x03 sets `reverse` to 0 and 0x04 sets it to 1.
  - 0x05 sets `all_on` to 0.
  - 0x06 sets `all_on` to 1 when the display is on.
- R3: All-points-on overrides reverse: `pix_all` equals `all_on`, and `pix_invert` is 1 only when `reverse` is 1 and `all_on` is 0.
- R4: Byte 0x09 arms a contrast write. The next byte's bits [5:0] are stored in `contrast`.
- R5: Byte 0x08 sets `ind_on` to 1 and arms an indicator write that stores the next byte's bits [1:0] in `ind_mode`. Byte 0x07 clears `ind_on` as a single byte and arms nothing.
- R6: Byte 0x0A arms a step-up write that stores the next byte's bits [1:0] in `boost_sel`.
- R7: While a write is armed, `await_data` is 1 and the next byte is never executed as a command. After that byte, `await_data` returns to 0.
- R8: Byte 0x06 received while `disp_on` is 0 sets `power_save` to 1 and `blank_n` to 0. It leaves `all_on` and `reverse` unchanged.
- R9: In power save, `supply_en` is 0.
  - When `ind_on` is 0 (sleep), `osc_en` is 0 and `standby` is 0.
  - When `ind_on` is 1 (standby), `osc_en` is 1 and `standby` is 1.
- R10: Byte 0x02 or byte 0x05 ends power save. The saved `reverse` value is still in effect afterwards.
- R11: Byte 0x0F (soft reset) does the following:
  - It returns `start_line`, `page_addr`, `col_addr`, `com_flip`, `res_ratio`, `contrast`, `ind_on` and `ind_mode` to their R1 values.
  - It keeps `disp_on`, `reverse`, `all_on`, `pwr_ctrl`, `boost_sel` and `power_save`.
  - Issued during standby, it therefore leaves the controller in sleep.
- R12: The setting commands are:
  - 0x10–0x17 load `pwr_ctrl` from bits [2:0].
  - 0x20–0x27 load `res_ratio` from bits [2:0].
  - 0x40–0x7F load `start_line` from bits [5:0].
  - 0x80–0x88 load `page_addr` from bits [3:0]; 0x89–0x8F are ignored.
  - 0xC0–0xCF load `col_addr[7:4]` and 0xD0–0xDF load `col_addr[3:0]`.
  - 0x0B clears `com_flip` and 0x0C sets it.
  - Any other byte changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | Byte strobe, one cycle per byte |
| cmd_byte | input | 8 | Command or data byte |
| disp_on | output | 1 | Display enabled |
| reverse | output | 1 | Reverse display selected |
| all_on | output | 1 | All-points-on selected |
| pix_invert | output | 1 | Effective pixel inversion |
| pix_all | output | 1 | Effective force of all pixels on |
| contrast | output | 6 | Contrast level |
| ind_on | output | 1 | Static indicator enabled |
| ind_mode | output | 2 | Static indicator mode |
| boost_sel | output | 2 | Step-up ratio selection |
| pwr_ctrl | output | 3 | Power control bits |
| res_ratio | output | 3 | Regulator resistor ratio |
| start_line | output | 6 | Display start line |
| page_addr | output | 4 | Page address |
| col_addr | output | 8 | Column address |
| com_flip | output | 1 | Common scan reversed |
| await_data | output | 1 | A two-byte command is waiting for its data byte |
| power_save | output | 1 | Power save active |
| standby | output | 1 | Power save is standby rather than sleep |
| osc_en | output | 1 | Oscillator enable |
| supply_en | output | 1 | Internal supply enable |
| blank_n | output | 1 | Active-low blanking output |

## Verification
The hardest state to reach is standby followed by a soft reset. The display must already be off, and the indicator must have been switched on through its two-byte form. Only then can the all-points command enter power save with the oscillator kept running. Only after that does the soft reset show the standby-to-sleep fall on `osc_en`. The stimulus builds this state step by step and checks each step before moving on. It also sends a soft-reset byte while an indicator write is armed, which shows that the lock swallows the byte as data.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  parameter int VOL_W     = 6;
  parameter int IND_W     = 2;
  parameter int BST_W     = 2;
  parameter int PWR_W     = 3;
  parameter int RAT_W     = 3;
  parameter int LINE_W    = 6;
  parameter int PAGE_W    = 4;
  parameter int COL_W     = 8;
  parameter int NIB_W     = COL_W / 2;
  parameter int PAGE_LAST = 8;
  parameter logic [VOL_W-1:0] VOL_RST = 6'b100000;

  typedef enum logic [4:0] {
    K_NONE, K_DOFF, K_DON, K_NORM, K_REV, K_AOFF, K_AON,
    K_SOFF, K_SON, K_VOL, K_BST, K_COMN, K_COMR, K_RST,
    K_PWR, K_RAT, K_LINE, K_PAGE, K_CHI, K_CLO
  } op_kind_e;

  typedef enum logic [1:0] {PD_NONE, PD_VOL, PD_IND, PD_BST} pend_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [7:0] arg;
  } op_t;

  typedef struct packed {
    logic              disp_on;
    logic              reverse;
    logic              all_on;
    logic [VOL_W-1:0]  vol;
    logic              ind_on;
    logic [IND_W-1:0]  ind_mode;
    logic [BST_W-1:0]  boost;
    logic [PWR_W-1:0]  pwr;
    logic [RAT_W-1:0]  ratio;
    logic [LINE_W-1:0] line;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic              com_flip;
  } cfg_t;
endpackage

// File: rtl/lcdseq_decode.sv
module lcdseq_decode
  import lcdseq_pkg::*;
(
  input  logic [7:0] byte_i,
  output op_t        op_o
);
  logic [3:0] hi;
  logic [3:0] lo;
  assign hi = byte_i[7:4];
  assign lo = byte_i[3:0];

  always_comb begin
    op_o.kind = K_NONE;
    op_o.arg  = byte_i;
    case (hi)
      4'h0: begin
        case (lo)
          4'h1: op_o.kind = K_DOFF;
          4'h2: op_o.kind = K_DON;
          4'h3: op_o.kind = K_NORM;
          4'h4: op_o.kind = K_REV;
          4'h5: op_o.kind = K_AOFF;
          4'h6: op_o.kind = K_AON;
          4'h7: op_o.kind = K_SOFF;
          4'h8: op_o.kind = K_SON;
          4'h9: op_o.kind = K_VOL;
          4'hA: op_o.kind = K_BST;
          4'hB: op_o.kind = K_COMN;
          4'hC: op_o.kind = K_COMR;
          4'hF: op_o.kind = K_RST;
          default: op_o.kind = K_NONE;
        endcase
      end
      4'h1: if (!lo[3]) op_o.kind = K_PWR;
      4'h2: if (!lo[3]) op_o.kind = K_RAT;
      4'h4, 4'h5, 4'h6, 4'h7: op_o.kind = K_LINE;
      4'h8: if (lo <= 4'(PAGE_LAST)) op_o.kind = K_PAGE;
      4'hC: op_o.kind = K_CHI;
      4'hD: op_o.kind = K_CLO;
      default: op_o.kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/lcdseq_prefix.sv
module lcdseq_prefix
  import lcdseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     valid_i,
  input  op_kind_e kind_i,
  output pend_e    pend_o,
  output logic     exec_o,
  output logic     data_wr_o
);
  pend_e pend_q;
  pend_e pend_d;

  assign exec_o    = valid_i && (pend_q == PD_NONE);
  assign data_wr_o = valid_i && (pend_q != PD_NONE);
  assign pend_o    = pend_q;

  always_comb begin
    pend_d = pend_q;
    if (data_wr_o) begin
      pend_d = PD_NONE;
    end else if (exec_o) begin
      case (kind_i)
        K_VOL:   pend_d = PD_VOL;
        K_SON:   pend_d = PD_IND;
        K_BST:   pend_d = PD_BST;
        default: pend_d = PD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_NONE;
    end else if (valid_i) begin
      pend_q <= pend_d;
    end
  end

  AST_PREFIX_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && pend_q != PD_NONE) |=> (pend_q == PD_NONE)); // R7
  AST_VOL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && kind_i == K_VOL) |=> (pend_q == PD_VOL)); // R4
endmodule

// File: rtl/lcdseq_regs.sv
module lcdseq_regs
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec_i,
  input  logic       data_wr_i,
  input  pend_e      pend_i,
  input  op_t        op_i,
  input  logic [7:0] byte_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;
  logic cfg_en;

  assign cfg_en = exec_i || data_wr_i;
  assign cfg_o  = cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (data_wr_i) begin
      case (pend_i)
        PD_VOL:  cfg_d.vol      = byte_i[VOL_W-1:0];
        PD_IND:  cfg_d.ind_mode = byte_i[IND_W-1:0];
        PD_BST:  cfg_d.boost    = byte_i[BST_W-1:0];
        default: ;
      endcase
    end else if (exec_i) begin
      case (op_i.kind)
        K_DOFF: cfg_d.disp_on  = 1'b0;
        K_DON:  cfg_d.disp_on  = 1'b1;
        K_NORM: cfg_d.reverse  = 1'b0;
        K_REV:  cfg_d.reverse  = 1'b1;
        K_AOFF: cfg_d.all_on   = 1'b0;
        K_AON:  if (cfg_q.disp_on) cfg_d.all_on = 1'b1;
        K_SOFF: cfg_d.ind_on   = 1'b0;
        K_SON:  cfg_d.ind_on   = 1'b1;
        K_COMN: cfg_d.com_flip = 1'b0;
        K_COMR: cfg_d.com_flip = 1'b1;
        K_PWR:  cfg_d.pwr      = op_i.arg[PWR_W-1:0];
        K_RAT:  cfg_d.ratio    = op_i.arg[RAT_W-1:0];
        K_LINE: cfg_d.line     = op_i.arg[LINE_W-1:0];
        K_PAGE: cfg_d.page     = op_i.arg[PAGE_W-1:0];
        K_CHI:  cfg_d.col[COL_W-1:NIB_W] = op_i.arg[NIB_W-1:0];
        K_CLO:  cfg_d.col[NIB_W-1:0]     = op_i.arg[NIB_W-1:0];
        K_RST: begin
          cfg_d.line     = '0;
          cfg_d.page     = '0;
          cfg_d.col      = '0;
          cfg_d.com_flip = 1'b0;
          cfg_d.ratio    = '0;
          cfg_d.vol      = VOL_RST;
          cfg_d.ind_on   = 1'b0;
          cfg_d.ind_mode = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.disp_on  <= 1'b0;
      cfg_q.reverse  <= 1'b0;
      cfg_q.all_on   <= 1'b0;
      cfg_q.vol      <= VOL_RST;
      cfg_q.ind_on   <= 1'b0;
      cfg_q.ind_mode <= '0;
      cfg_q.boost    <= '0;
      cfg_q.pwr      <= '0;
      cfg_q.ratio    <= '0;
      cfg_q.line     <= '0;
      cfg_q.page     <= '0;
      cfg_q.col      <= '0;
      cfg_q.com_flip <= 1'b0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  AST_VOL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_i && pend_i == PD_VOL) |=> (cfg_q.vol == $past(byte_i[VOL_W-1:0]))); // R4
  AST_LOCK_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_i |=> ($stable(cfg_q.disp_on) && $stable(cfg_q.reverse) && $stable(cfg_q.all_on))); // R7
endmodule

// File: rtl/lcdseq_psave.sv
module lcdseq_psave
  import lcdseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     exec_i,
  input  op_kind_e kind_i,
  input  logic     disp_on_i,
  input  logic     ind_on_i,
  output logic     ps_o,
  output logic     standby_o,
  output logic     osc_en_o,
  output logic     supply_en_o,
  output logic     blank_n_o
);
  logic ps_q;
  logic ps_d;

  always_comb begin
    ps_d = ps_q;
    case (kind_i)
      K_AON:        if (!disp_on_i) ps_d = 1'b1;
      K_DON, K_AOFF: ps_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= 1'b0;
    end else if (exec_i) begin
      ps_q <= ps_d;
    end
  end

  assign ps_o        = ps_q;
  assign standby_o   = ps_q && ind_on_i;
  assign osc_en_o    = !ps_q || ind_on_i;
  assign supply_en_o = !ps_q;
  assign blank_n_o   = !ps_q;

  AST_PS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && kind_i == K_AON && !disp_on_i) |=> ps_q); // R8
  AST_PS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (kind_i == K_DON || kind_i == K_AOFF)) |=> !ps_q); // R10
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_byte,
  output logic              disp_on,
  output logic              reverse,
  output logic              all_on,
  output logic              pix_invert,
  output logic              pix_all,
  output logic [VOL_W-1:0]  contrast,
  output logic              ind_on,
  output logic [IND_W-1:0]  ind_mode,
  output logic [BST_W-1:0]  boost_sel,
  output logic [PWR_W-1:0]  pwr_ctrl,
  output logic [RAT_W-1:0]  res_ratio,
  output logic [LINE_W-1:0] start_line,
  output logic [PAGE_W-1:0] page_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic              com_flip,
  output logic              await_data,
  output logic              power_save,
  output logic              standby,
  output logic              osc_en,
  output logic              supply_en,
  output logic              blank_n
);
  op_t   op;
  pend_e pend;
  logic  exec;
  logic  data_wr;
  cfg_t  cfg;

  lcdseq_decode u_decode (
    .byte_i (cmd_byte),
    .op_o   (op)
  );

  lcdseq_prefix u_prefix (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (cmd_valid),
    .kind_i    (op.kind),
    .pend_o    (pend),
    .exec_o    (exec),
    .data_wr_o (data_wr)
  );

  lcdseq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_i    (exec),
    .data_wr_i (data_wr),
    .pend_i    (pend),
    .op_i      (op),
    .byte_i    (cmd_byte),
    .cfg_o     (cfg)
  );

  lcdseq_psave u_psave (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_i      (exec),
    .kind_i      (op.kind),
    .disp_on_i   (cfg.disp_on),
    .ind_on_i    (cfg.ind_on),
    .ps_o        (power_save),
    .standby_o   (standby),
    .osc_en_o    (osc_en),
    .supply_en_o (supply_en),
    .blank_n_o   (blank_n)
  );

  assign disp_on    = cfg.disp_on;
  assign reverse    = cfg.reverse;
  assign all_on     = cfg.all_on;
  assign pix_all    = cfg.all_on;
  assign pix_invert = cfg.reverse && !cfg.all_on;
  assign contrast   = cfg.vol;
  assign ind_on     = cfg.ind_on;
  assign ind_mode   = cfg.ind_mode;
  assign boost_sel  = cfg.boost;
  assign pwr_ctrl   = cfg.pwr;
  assign res_ratio  = cfg.ratio;
  assign start_line = cfg.line;
  assign page_addr  = cfg.page;
  assign col_addr   = cfg.col;
  assign com_flip   = cfg.com_flip;
  assign await_data = (pend != PD_NONE);

  AST_PS_DISPLAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    power_save |-> !disp_on); // R8
  AST_PS_KEEPS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_save) |-> ($stable(all_on) && $stable(reverse))); // R8
endmodule

// File: tb/lcd_cmd_seq_bench.sv
module lcd_cmd_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       disp_on, reverse, all_on, pix_invert, pix_all;
  logic [5:0] contrast;
  logic       ind_on;
  logic [1:0] ind_mode, boost_sel;
  logic [2:0] pwr_ctrl, res_ratio;
  logic [5:0] start_line;
  logic [3:0] page_addr;
  logic [7:0] col_addr;
  logic       com_flip, await_data, power_save, standby, osc_en, supply_en, blank_n;

  int total = 0;
  int bad   = 0;

  lcd_cmd_seq u_lcd_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .disp_on(disp_on), .reverse(reverse), .all_on(all_on),
    .pix_invert(pix_invert), .pix_all(pix_all), .contrast(contrast),
    .ind_on(ind_on), .ind_mode(ind_mode), .boost_sel(boost_sel),
    .pwr_ctrl(pwr_ctrl), .res_ratio(res_ratio), .start_line(start_line),
    .page_addr(page_addr), .col_addr(col_addr), .com_flip(com_flip),
    .await_data(await_data), .power_save(power_save), .standby(standby),
    .osc_en(osc_en), .supply_en(supply_en), .blank_n(blank_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1", "blank_n in reset", int'(blank_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "disp_on", int'(disp_on), 0);
    chk("R1", "reverse", int'(reverse), 0);
    chk("R1", "all_on", int'(all_on), 0);
    chk("R1", "contrast", int'(contrast), 'h20);
    chk("R1", "pwr_ctrl", int'(pwr_ctrl), 0);
    chk("R1", "ind_on", int'(ind_on), 0);
    chk("R1", "power_save", int'(power_save), 0);
    chk("R1", "await_data", int'(await_data), 0);
    chk("R1", "col/page/line", int'({col_addr, page_addr, start_line}), 0);
    chk("R1", "blank_n", int'(blank_n), 1);
  endtask

  task automatic t_display();
    send(8'h02); chk("R2", "disp on", int'(disp_on), 1);
    send(8'h04); chk("R2", "reverse", int'(reverse), 1);
    chk("R3", "invert", int'(pix_invert), 1);
    send(8'h06); chk("R2", "all_on", int'(all_on), 1);
    chk("R3", "pix_all", int'(pix_all), 1);
    chk("R3", "invert overridden", int'(pix_invert), 0);
    chk("R8", "no ps with display on", int'(power_save), 0);
    send(8'h05); chk("R2", "all off", int'(all_on), 0);
    chk("R3", "invert back", int'(pix_invert), 1);
    send(8'h03); chk("R2", "normal", int'(reverse), 0);
    send(8'h01); chk("R2", "disp off", int'(disp_on), 0);
  endtask

  task automatic t_contrast();
    send(8'h09);
    chk("R7", "await after prefix", int'(await_data), 1);
    chk("R4", "contrast unchanged", int'(contrast), 'h20);
    send(8'h02);
    chk("R4", "contrast written", int'(contrast), 'h02);
    chk("R7", "data byte not executed", int'(disp_on), 0);
    chk("R7", "await cleared", int'(await_data), 0);
  endtask

  task automatic t_indicator();
    send(8'h08);
    chk("R5", "ind_on set", int'(ind_on), 1);
    chk("R7", "await ind", int'(await_data), 1);
    send(8'h0F);
    chk("R5", "ind_mode", int'(ind_mode), 3);
    chk("R7", "reset byte swallowed", int'(contrast), 'h02);
    send(8'h07);
    chk("R5", "ind off", int'(ind_on), 0);
    chk("R5", "off single byte", int'(await_data), 0);
  endtask

  task automatic t_boost();
    send(8'h0A);
    send(8'h06);
    chk("R6", "boost", int'(boost_sel), 2);
    chk("R7", "all_on untouched", int'(all_on), 0);
    chk("R7", "no ps from data", int'(power_save), 0);
  endtask

  task automatic t_settings();
    send(8'h15); chk("R12", "pwr", int'(pwr_ctrl), 5);
    send(8'h23); chk("R12", "ratio", int'(res_ratio), 3);
    send(8'h6A); chk("R12", "line", int'(start_line), 'h2A);
    send(8'h88); chk("R12", "page 8", int'(page_addr), 8);
    send(8'h89); chk("R12", "page 9 ignored", int'(page_addr), 8);
    send(8'hC7); send(8'hD2); chk("R12", "column", int'(col_addr), 'h72);
    send(8'h0C); chk("R12", "com flip", int'(com_flip), 1);
    send(8'hFF); chk("R12", "unknown ignored", int'({col_addr, page_addr, pwr_ctrl}), int'({8'h72, 4'h8, 3'h5}));
  endtask

  task automatic t_sleep();
    send(8'h04);
    send(8'h06);
    chk("R8", "ps entered", int'(power_save), 1);
    chk("R8", "blank low", int'(blank_n), 0);
    chk("R8", "all_on kept", int'(all_on), 0);
    chk("R8", "reverse kept", int'(reverse), 1);
    chk("R9", "sleep osc", int'(osc_en), 0);
    chk("R9", "sleep supply", int'(supply_en), 0);
    chk("R9", "not standby", int'(standby), 0);
    send(8'h02);
    chk("R10", "ps exit", int'(power_save), 0);
    chk("R10", "reverse restored", int'(pix_invert), 1);
    chk("R10", "blank high", int'(blank_n), 1);
    send(8'h01);
    send(8'h06);
    send(8'h05);
    chk("R10", "exit by all off", int'(power_save), 0);
  endtask

  task automatic t_standby();
    send(8'h08); send(8'h01);
    send(8'h06);
    chk("R9", "standby", int'(standby), 1);
    chk("R9", "standby osc", int'(osc_en), 1);
    chk("R9", "standby supply", int'(supply_en), 0);
    send(8'h0F);
    chk("R11", "to sleep", int'(standby), 0);
    chk("R11", "osc stops", int'(osc_en), 0);
    chk("R11", "still ps", int'(power_save), 1);
    chk("R11", "contrast", int'(contrast), 'h20);
    chk("R11", "addr cleared", int'({col_addr, page_addr, start_line}), 0);
    chk("R11", "com/ratio", int'({com_flip, res_ratio, ind_mode}), 0);
    chk("R11", "pwr kept", int'(pwr_ctrl), 5);
    chk("R11", "boost kept", int'(boost_sel), 2);
    chk("R11", "reverse kept", int'(reverse), 1);
    send(8'h05);
    chk("R10", "exit", int'(power_save), 0);
  endtask

  initial begin
    t_reset();
    t_display();
    t_contrast();
    t_indicator();
    t_boost();
    t_settings();
    t_sleep();
    t_standby();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule